// File: doc/BRIEF.md
# Serial Flash Status Register and Write-Protection Logic

This block keeps the status and control byte of a serial flash device and enforces the rules that decide which of its bits may change. It reports whether an internal cycle is running and whether writes are armed. It holds a four-bit protected-area code that the array controller uses to refuse program and erase inside the protected region. One bit disables the write-protect and hold pins. A protect bit works together with the write-protect pin to freeze the protection settings. In one-time-programmable (OTP) mode the top bit instead reads and sets a one-way lock on the OTP sector.

The serial front end decodes commands and drives the strobes: set-latch, clear-latch and status-write with its data byte. The program/erase engine reports busy and done. A status write takes a fixed number of clock cycles (`WR_CYCLES`). The new contents become visible when that window closes. Non-volatile fields are reset only by the power-on reset. The soft reset clears the volatile latch and abandons any status write still in flight.

Top module: `flash_sr_core`

## Requirements
- R1: After power-on reset the status byte reads 0x00, `prot_code` is 0, `pin_en` is 1, `hw_prot` is 0 and `otp_lock` is 0.
- R2: Status bit 0 (busy) reads 1 whenever `eng_busy` is 1. It also reads 1 for exactly `WR_CYCLES` clock cycles after an accepted status write.
- R3: Status bit 1 (write latch) is set by `wren` and cleared by `wrdi`, with `wrdi` winning if both are present. Both strobes are ignored while bit 0 is 1. The latch is cleared by `eng_done` and when a status write completes.
- R4: A status-write request is accepted only when bit 1 is 1 and bit 0 is 0. Otherwise it has no effect on any output.
- R5: When an accepted write completes, status bits 5:2 take data bits 5:2, and `prot_code` equals status bits 5:2.
- R6: Status bit 6 is the pin-disable bit, written from data bit 6. `pin_en` is its inverse. While it is 1 the `wp_n` level has no effect and `hw_prot` stays 0.
- R7: `hw_prot` is 1 when status bit 7 is 1, `wp_n` is 0 and bit 6 is 0. A write accepted in that state leaves bits 7 and 5:2 unchanged and still writes bit 6.
- R8: While `otp_mode` is 1, status bit 7 reads the OTP lock. A write with data bit 7 = 1 sets the lock and leaves the protect bit unchanged.
- R9: The OTP lock can only go from 0 to 1. Writes cannot clear it, and neither can soft reset or leaving OTP mode. Only power-on reset clears it.
- R10: Soft reset clears bit 1 and cancels an in-flight status write, and it keeps bits 7:2 and the OTP lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async active low; clears all state |
| srst_n | input | 1 | Soft reset, async active low; clears volatile state only |
| wrsr_req | input | 1 | Status-write request strobe |
| wrsr_data | input | 8 | Data byte for the status write |
| wren | input | 1 | Set write latch strobe |
| wrdi | input | 1 | Clear write latch strobe |
| eng_busy | input | 1 | Program/erase engine is running |
| eng_done | input | 1 | Program/erase engine finished (one cycle) |
| wp_n | input | 1 | Write-protect pin level, active low |
| otp_mode | input | 1 | Device is in OTP access mode |
| sr_rd | output | 8 | Readable status byte |
| prot_code | output | 4 | Protected-area code for the array controller |
| pin_en | output | 1 | Write-protect and hold pins honoured |
| hw_prot | output | 1 | Hardware-protected mode active |
| otp_lock | output | 1 | OTP sector locked against program/erase |

## Verification
The bench targets the length of the busy window. A timer that is off by one gives one cycle too many or too few of bit 0 and shifts the commit by that cycle. It drives the set-latch strobe and status writes during engine activity. A design that ignored busy would arm the latch or start a write there. It writes with the protect bit set and the pin low, before and after disabling the pins. This catches a design that freezes the wrong fields or still honours the pin once disabled. It also issues a soft reset in the middle of a write and tries to clear the OTP lock. A design that lets the pending data land, loses non-volatile bits or clears the lock shows the wrong status byte.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

  localparam int unsigned SR_W    = 8;
  localparam int unsigned BP_W    = 4;
  localparam int unsigned WIP_BIT = 0;
  localparam int unsigned WEL_BIT = 1;
  localparam int unsigned BP_LSB  = 2;
  localparam int unsigned DIS_BIT = BP_LSB + BP_W;
  localparam int unsigned SRP_BIT = DIS_BIT + 1;

  typedef struct packed {
    logic            srp;
    logic            dis;
    logic [BP_W-1:0] bp;
  } nv_fields_t;

  // Next non-volatile contents for a write: frozen fields keep their value.
  function automatic nv_fields_t sr_merge(
    input nv_fields_t      cur,
    input logic [SR_W-1:0] data,
    input logic            frozen,
    input logic            otp
  );
    nv_fields_t n;
    n.dis = data[DIS_BIT];
    n.bp  = frozen ? cur.bp : data[BP_LSB +: BP_W];
    n.srp = (frozen || otp) ? cur.srp : data[SRP_BIT];
    return n;
  endfunction

endpackage

// File: rtl/fsr_rst_sync.sv
module fsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/fsr_wr_timer.sv
module fsr_wr_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    finish = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        finish = 1'b1;
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/fsr_nv_store.sv
module fsr_nv_store
  import flash_sr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            commit,
  input  logic [SR_W-1:0] wr_data,
  input  logic            frozen,
  input  logic            otp_mode,
  output nv_fields_t      fields_o,
  output logic            otp_lock_o
);
  nv_fields_t cur_q, cur_d, pend_q, pend_d;
  logic       lock_q, lock_d, pset_q, pset_d;

  always_comb begin
    pend_d = pend_q;
    pset_d = pset_q;
    cur_d  = cur_q;
    lock_d = lock_q;
    if (accept) begin
      pend_d = sr_merge(cur_q, wr_data, frozen, otp_mode);
      pset_d = otp_mode & wr_data[SRP_BIT];
    end
    if (commit) begin
      cur_d  = pend_q;
      lock_d = lock_q | pset_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      pend_q <= '0;
      lock_q <= 1'b0;
      pset_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      pend_q <= pend_d;
      lock_q <= lock_d;
      pset_q <= pset_d;
    end
  end

  assign fields_o   = cur_q;
  assign otp_lock_o = lock_q;
endmodule

// File: rtl/flash_sr_core.sv
module flash_sr_core
  import flash_sr_pkg::*;
#(
  parameter int unsigned WR_CYCLES   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            srst_n,
  input  logic            wrsr_req,
  input  logic [SR_W-1:0] wrsr_data,
  input  logic            wren,
  input  logic            wrdi,
  input  logic            eng_busy,
  input  logic            eng_done,
  input  logic            wp_n,
  input  logic            otp_mode,
  output logic [SR_W-1:0] sr_rd,
  output logic [BP_W-1:0] prot_code,
  output logic            pin_en,
  output logic            hw_prot,
  output logic            otp_lock
);
  logic       nv_rst_n, vol_rst_n;
  logic       wr_busy, wr_done, accept, wip;
  logic       wel_q, wel_d;
  nv_fields_t nv;

  fsr_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .rst_n_o(nv_rst_n)
  );
  fsr_rst_sync #(.STAGES(SYNC_STAGES)) u_vol_sync (
    .clk(clk), .arst_n(por_n & srst_n), .rst_n_o(vol_rst_n)
  );

  assign wip    = eng_busy | wr_busy;
  assign accept = wrsr_req & wel_q & ~wip;

  fsr_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(vol_rst_n), .start(accept),
    .busy(wr_busy), .finish(wr_done)
  );

  assign hw_prot = nv.srp & ~wp_n & ~nv.dis;

  fsr_nv_store u_nv (
    .clk(clk), .rst_n(nv_rst_n), .accept(accept), .commit(wr_done),
    .wr_data(wrsr_data), .frozen(hw_prot), .otp_mode(otp_mode),
    .fields_o(nv), .otp_lock_o(otp_lock)
  );

  always_comb begin
    wel_d = wel_q;
    if (wr_done || eng_done) wel_d = 1'b0;
    else if (!wip) begin
      if (wrdi)      wel_d = 1'b0;
      else if (wren) wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge vol_rst_n) begin
    if (!vol_rst_n) wel_q <= 1'b0;
    else            wel_q <= wel_d;
  end

  always_comb begin
    sr_rd                     = '0;
    sr_rd[WIP_BIT]            = wip;
    sr_rd[WEL_BIT]            = wel_q;
    sr_rd[BP_LSB +: BP_W]     = nv.bp;
    sr_rd[DIS_BIT]            = nv.dis;
    sr_rd[SRP_BIT]            = otp_mode ? otp_lock : nv.srp;
  end

  assign prot_code = nv.bp;
  assign pin_en    = ~nv.dis;
endmodule

// File: rtl/flash_sr_chk.sv
module flash_sr_chk (
  input logic       clk,
  input logic       nv_rst_n,
  input logic       vol_rst_n,
  input logic       wr_busy,
  input logic       wrsr_req,
  input logic       eng_busy,
  input logic       otp_mode,
  input logic       otp_lock,
  input logic [7:0] sr_rd
);
  // R2
  busy_flag_chk: assert property (@(posedge clk) disable iff (!vol_rst_n)
    eng_busy |-> sr_rd[0]);
  // R3
  wel_clear_on_commit_chk: assert property (@(posedge clk) disable iff (!vol_rst_n)
    $fell(wr_busy) |-> !sr_rd[1]);
  // R4
  no_start_unarmed_chk: assert property (@(posedge clk) disable iff (!vol_rst_n)
    (wrsr_req && !sr_rd[1]) |=> !$rose(wr_busy));
  // R8
  otp_bit_view_chk: assert property (@(posedge clk) disable iff (!nv_rst_n)
    otp_mode |-> (sr_rd[7] == otp_lock));
  // R9
  otp_lock_sticky_chk: assert property (@(posedge clk) disable iff (!nv_rst_n)
    otp_lock |=> otp_lock);
endmodule

bind flash_sr_core flash_sr_chk u_chk (
  .clk(clk), .nv_rst_n(nv_rst_n), .vol_rst_n(vol_rst_n), .wr_busy(wr_busy),
  .wrsr_req(wrsr_req), .eng_busy(eng_busy), .otp_mode(otp_mode),
  .otp_lock(otp_lock), .sr_rd(sr_rd)
);

// File: tb/flash_sr_core_bench.sv
`timescale 1ns/1ps
module flash_sr_core_bench;
  localparam int WR = 8;

  logic       clk = 1'b0;
  logic       por_n, srst_n, wrsr_req, wren, wrdi, eng_busy, eng_done, wp_n, otp_mode;
  logic [7:0] wrsr_data;
  logic [7:0] sr_rd;
  logic [3:0] prot_code;
  logic       pin_en, hw_prot, otp_lock;

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 0, finished = 0;

  always #4 clk = ~clk;

  flash_sr_core #(.WR_CYCLES(WR)) u_flash_sr_core (
    .clk(clk), .por_n(por_n), .srst_n(srst_n), .wrsr_req(wrsr_req),
    .wrsr_data(wrsr_data), .wren(wren), .wrdi(wrdi), .eng_busy(eng_busy),
    .eng_done(eng_done), .wp_n(wp_n), .otp_mode(otp_mode), .sr_rd(sr_rd),
    .prot_code(prot_code), .pin_en(pin_en), .hw_prot(hw_prot), .otp_lock(otp_lock)
  );

  // Behavioural reference model
  int  m_cnt;
  bit  m_busy, m_wel, m_srp, m_dis, m_lock, p_srp, p_dis, p_set;
  bit [3:0] m_bp, p_bp;

  always @(posedge clk) begin
    bit wip, acc, fin, frz;
    if (!por_n) begin
      m_busy = 0; m_cnt = 0; m_wel = 0; m_srp = 0; m_dis = 0; m_bp = 0; m_lock = 0;
      p_srp = 0; p_dis = 0; p_bp = 0; p_set = 0;
    end else if (!srst_n) begin
      m_busy = 0; m_cnt = 0; m_wel = 0;
    end else begin
      wip = eng_busy || m_busy;
      acc = wrsr_req && m_wel && !wip;
      frz = m_srp && !wp_n && !m_dis;
      fin = 0;
      if (m_busy) begin
        if (m_cnt == 1) begin fin = 1; m_busy = 0; end
        else m_cnt = m_cnt - 1;
      end else if (acc) begin
        m_busy = 1; m_cnt = WR;
      end
      if (m_wel && (fin || eng_done)) m_wel = 0;
      else if (!fin && !eng_done && !wip) begin
        if (wrdi) m_wel = 0; else if (wren) m_wel = 1;
      end
      if (fin) begin
        m_srp = p_srp; m_dis = p_dis; m_bp = p_bp;
        if (p_set) m_lock = 1;
      end
      if (acc) begin
        p_dis = wrsr_data[6];
        p_bp  = frz ? m_bp : wrsr_data[5:2];
        p_srp = (frz || otp_mode) ? m_srp : wrsr_data[7];
        p_set = otp_mode && wrsr_data[7];
      end
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [7:0] e;
    e[0] = eng_busy || m_busy;
    e[1] = m_wel;
    e[5:2] = m_bp;
    e[6] = m_dis;
    e[7] = otp_mode ? m_lock : m_srp;
    cmp("R2", "busy bit", sr_rd[0], e[0]);
    cmp("R3", "latch bit", sr_rd[1], e[1]);
    cmp("R5", "area bits", sr_rd[5:2], e[5:2]);
    cmp("R5", "prot_code", prot_code, m_bp);
    cmp("R6", "disable bit", sr_rd[6], e[6]);
    cmp("R6", "pin_en", pin_en, !m_dis);
    cmp("R8", "bit7", sr_rd[7], e[7]);
    cmp("R7", "hw_prot", hw_prot, m_srp && !wp_n && !m_dis);
    cmp("R9", "otp_lock", otp_lock, m_lock);
  endtask

  task automatic cyc();
    @(negedge clk);
    if (cmp_en) compare_all();
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_wren();
    wren = 1; cyc(); wren = 0;
  endtask

  task automatic do_wrsr(logic [7:0] d);
    wrsr_data = d; wrsr_req = 1; cyc(); wrsr_req = 0;
  endtask

  task automatic full_write(logic [7:0] d);
    do_wren(); do_wrsr(d); wait_n(WR + 1);
  endtask

  task automatic do_por();
    cmp_en = 0; por_n = 0; srst_n = 1; wait_n(3); por_n = 1; wait_n(4); cmp_en = 1;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int wip_cnt;
    por_n = 0; srst_n = 1; wrsr_req = 0; wrsr_data = 0; wren = 0; wrdi = 0;
    eng_busy = 0; eng_done = 0; wp_n = 1; otp_mode = 0;
    do_por();
    // R1 reset state
    cmp("R1", "status after por", sr_rd, 8'h00);
    cmp("R1", "pin_en after por", pin_en, 1);
    cmp("R1", "otp_lock after por", otp_lock, 0);

    // R4 write without latch
    do_wrsr(8'hFC); wait_n(WR + 2);
    cmp("R4", "unarmed write ignored", sr_rd, 8'h00);

    // R5 + R2 write with latch, count busy window
    do_wren();
    cmp("R3", "latch set", sr_rd[1], 1);
    do_wrsr(8'h3C);
    wip_cnt = 0;
    for (int i = 0; i < WR + 4; i++) begin
      if (sr_rd[0]) wip_cnt++;
      cyc();
    end
    cmp("R2", "busy window length", wip_cnt, WR);
    cmp("R5", "area committed", sr_rd, 8'h3C);

    // R3 wrdi wins, strobes ignored while engine busy
    wren = 1; wrdi = 1; cyc(); wren = 0; wrdi = 0;
    cmp("R3", "wrdi wins", sr_rd[1], 0);
    eng_busy = 1; cyc(); do_wren();
    cmp("R3", "wren ignored while busy", sr_rd[1], 0);
    eng_busy = 0; do_wren(); eng_busy = 1;
    do_wrsr(8'h00); wait_n(WR + 2);
    cmp("R4", "write refused while engine busy", sr_rd[5:2], 4'hF);
    eng_done = 1; cyc(); eng_done = 0; eng_busy = 0; cyc();
    cmp("R3", "eng_done clears latch", sr_rd[1], 0);

    // R7 hardware protection
    full_write(8'h94);
    wp_n = 0; cyc();
    cmp("R7", "hw_prot entered", hw_prot, 1);
    full_write(8'h40);
    cmp("R7", "frozen fields kept, bit6 written", sr_rd, 8'hD4);
    // R6 pins disabled: wp_n ignored
    cmp("R6", "hw_prot off when pins disabled", hw_prot, 0);
    full_write(8'h00);
    cmp("R6", "write passes with wp_n low", sr_rd, 8'h00);
    wp_n = 1;

    // R10 soft reset mid-write
    full_write(8'h08);
    do_wren(); do_wrsr(8'h30); wait_n(3);
    cmp_en = 0; srst_n = 0; wait_n(2); srst_n = 1; wait_n(4); cmp_en = 1;
    cmp("R10", "nv kept, write cancelled", sr_rd, 8'h08);
    wait_n(WR);
    cmp("R10", "no late commit", sr_rd, 8'h08);

    // R8 OTP lock
    otp_mode = 1; cyc();
    full_write(8'h88);
    cmp("R8", "lock visible in bit7", sr_rd[7], 1);
    cmp("R8", "otp_lock set", otp_lock, 1);
    full_write(8'h08);
    cmp("R9", "lock not cleared by write", otp_lock, 1);
    cmp_en = 0; srst_n = 0; wait_n(2); srst_n = 1; wait_n(4); cmp_en = 1;
    cmp("R9", "lock survives soft reset", otp_lock, 1);
    otp_mode = 0; cyc();
    cmp("R8", "protect bit untouched by otp write", sr_rd[7], 0);
    cmp("R9", "lock survives leaving otp mode", otp_lock, 1);

    do_por();
    cmp("R9", "por clears lock", otp_lock, 0);
    cmp("R1", "status after second por", sr_rd, 8'h00);
    report();
  end
endmodule